// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches virtual-to-physical page translations for one memory pipe. Every slot keeps a virtual page tag, a physical page number, the number of the address space that installed it, a global flag, a valid flag, per-privilege-mode read and write enable masks, and two trap-on-access flags (one for reads, one for writes). A lookup compares the page number of a virtual address with all slots at once. A slot answers only if it belongs to the requesting address space or is marked global. The fields of the answering slot come back one cycle later.

Software keeps the buffer up to date with four commands. The first installs a translation in the slot named by a rotating replacement pointer. The second empties the buffer. The third drops every translation that is not global, for use on a context switch. The fourth drops the translations for one page as seen from one address space. Pages are 8 KB, so the page number is the virtual address with its low 13 bits removed. Depth defaults to 64 and an instruction-side instance would use 48. Walking the page table, deciding on permissions and counting events are left to the neighbouring logic.

Top module: `asn_tlb`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is 0 and `rsp_valid_o` is 0. A lookup on the empty buffer reports a miss.
- R2: A slot matches when it is valid, its tag equals `va_i[VA_W-1:13]`, and either its global flag is 1 or its stored address-space number equals `asn_i`. The low 13 bits of `va_i` (the page offset) have no effect on matching.
- R3: An insert writes the slot named by the replacement pointer and then advances the pointer by one. The pointer wraps from DEPTH-1 to 0. Whatever translation was in that slot, global or not, is lost.
- R4: An insert stores the page number of `va_i` as the tag, `asn_i` as the address-space number, the `ins_*` fields as given, and sets the slot valid.
- R5: Flush-all clears every field of every slot and returns the replacement pointer to 0, so the next insert lands in slot 0.
- R6: Flush-process invalidates every valid slot whose global flag is 0. Global slots stay valid.
- R7: Flush-address invalidates every slot that matches `va_i` and `asn_i` under the rule of R2. A global slot for that page is removed whatever `asn_i` is, and a non-global slot of another address space is kept.
- R8: The result of a lookup is registered. `rsp_valid_o` is 1 in exactly the cycle after a lookup command. On a miss `rsp_hit_o` is 0 and every returned field is zero.
- R9: When several slots match, the response reports the one with the lowest index, in both `rsp_idx_o` and its fields.
- R10: `cmd_i` encodes 0 idle, 1 lookup, 2 insert, 3 flush-all, 4 flush-process and 5 flush-address. Codes 6 and 7 act as idle and change no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Command code (R10) |
| va_i | input | VA_W | Virtual address for lookup, insert or flush-address |
| asn_i | input | ASN_W | Address-space number of the request, or of the inserted entry |
| ins_ppn_i | input | PPN_W | Physical page number to insert |
| ins_global_i | input | 1 | Global flag to insert |
| ins_rd_en_i | input | MODES | Per-mode read enables to insert |
| ins_wr_en_i | input | MODES | Per-mode write enables to insert |
| ins_for_i | input | 1 | Trap-on-read flag to insert |
| ins_fow_i | input | 1 | Trap-on-write flag to insert |
| rsp_valid_o | output | 1 | Lookup response present |
| rsp_hit_o | output | 1 | A slot matched |
| rsp_idx_o | output | IDX_W | Index of the matching slot |
| rsp_ppn_o | output | PPN_W | Physical page number of the match |
| rsp_asn_o | output | ASN_W | Stored address-space number of the match |
| rsp_global_o | output | 1 | Global flag of the match |
| rsp_rd_en_o | output | MODES | Read enables of the match |
| rsp_wr_en_o | output | MODES | Write enables of the match |
| rsp_for_o | output | 1 | Trap-on-read flag of the match |
| rsp_fow_o | output | 1 | Trap-on-write flag of the match |

## Verification
The hardest state to reach from the ports is two valid slots that hold the same tag for the same address space. That state is needed to check both the lowest-index rule and a flush-address that removes more than one slot. The bench builds it with a depth of 4 and fills every slot once. It then inserts a fifth translation, so the pointer wraps and the new entry lands in slot 0, while slot 3 still holds the same page and address space. From there it checks that eviction removed the old slot 0. It also checks that a global slot is lost to replacement but not to flush-process.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;

   typedef enum logic [2:0] {
      CMD_IDLE       = 3'd0,
      CMD_LOOKUP     = 3'd1,
      CMD_INSERT     = 3'd2,
      CMD_FLUSH_ALL  = 3'd3,
      CMD_FLUSH_PROC = 3'd4,
      CMD_FLUSH_ADDR = 3'd5
   } tlb_cmd_e;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
   parameter int VPN_W = 30,
   parameter int PPN_W = 28,
   parameter int ASN_W = 8,
   parameter int MODES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic             kill_i,
   input  logic [VPN_W-1:0] wr_tag_i,
   input  logic [PPN_W-1:0] wr_ppn_i,
   input  logic [ASN_W-1:0] wr_asn_i,
   input  logic             wr_glob_i,
   input  logic [MODES-1:0] wr_rd_i,
   input  logic [MODES-1:0] wr_wm_i,
   input  logic             wr_for_i,
   input  logic             wr_fow_i,
   input  logic [VPN_W-1:0] lk_vpn_i,
   input  logic [ASN_W-1:0] lk_asn_i,
   output logic             match_o,
   output logic             valid_o,
   output logic             glob_o,
   output logic [PPN_W-1:0] ppn_o,
   output logic [ASN_W-1:0] asn_o,
   output logic [MODES-1:0] rd_o,
   output logic [MODES-1:0] wm_o,
   output logic             for_o,
   output logic             fow_o
);

   logic [VPN_W-1:0] tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || clr_i) begin
         valid_o <= 1'b0;
         tag_q   <= '0;
         ppn_o   <= '0;
         asn_o   <= '0;
         glob_o  <= 1'b0;
         rd_o    <= '0;
         wm_o    <= '0;
         for_o   <= 1'b0;
         fow_o   <= 1'b0;
      end else if (wr_i) begin
         valid_o <= 1'b1;
         tag_q   <= wr_tag_i;
         ppn_o   <= wr_ppn_i;
         asn_o   <= wr_asn_i;
         glob_o  <= wr_glob_i;
         rd_o    <= wr_rd_i;
         wm_o    <= wr_wm_i;
         for_o   <= wr_for_i;
         fow_o   <= wr_fow_i;
      end else if (kill_i) begin
         valid_o <= 1'b0;
      end
   end

   assign match_o = valid_o && (tag_q == lk_vpn_i) && (glob_o || (asn_o == lk_asn_i));

   AST_INSERT_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && !clr_i |=> valid_o && ppn_o == $past(wr_ppn_i)); // R4
   AST_KILL_DROPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      kill_i && !wr_i && !clr_i |=> !valid_o); // R7
   AST_CLEAR_WIPES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !valid_o && ppn_o == '0 && !glob_o); // R5

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             clr_i,
   output logic [IDX_W-1:0] ptr_o
);

   logic [IDX_W-1:0] nxt;

   generate
      if ((1 << IDX_W) == DEPTH) begin : g_pow2
         assign nxt = ptr_o + 1'b1;
      end else begin : g_mod
         assign nxt = (ptr_o == IDX_W'(DEPTH - 1)) ? '0 : ptr_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ptr_o <= '0;
      else if (clr_i) ptr_o <= '0;
      else if (adv_i) ptr_o <= nxt;
   end

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !clr_i && ptr_o == IDX_W'(DEPTH - 1) |=> ptr_o == '0); // R3
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i && !clr_i && ptr_o != IDX_W'(DEPTH - 1) |=> ptr_o == $past(ptr_o) + 1'b1); // R3
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i && !clr_i |=> $stable(ptr_o)); // R3
   AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> ptr_o == '0); // R5

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int N = 64,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |vec_i;

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
   import asn_tlb_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int VA_W      = 43,
   parameter int PAGE_BITS = 13,
   parameter int PPN_W     = 28,
   parameter int ASN_W     = 8,
   parameter int MODES     = 4,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd_i,
   input  logic [VA_W-1:0]  va_i,
   input  logic [ASN_W-1:0] asn_i,
   input  logic [PPN_W-1:0] ins_ppn_i,
   input  logic             ins_global_i,
   input  logic [MODES-1:0] ins_rd_en_i,
   input  logic [MODES-1:0] ins_wr_en_i,
   input  logic             ins_for_i,
   input  logic             ins_fow_i,
   output logic             rsp_valid_o,
   output logic             rsp_hit_o,
   output logic [IDX_W-1:0] rsp_idx_o,
   output logic [PPN_W-1:0] rsp_ppn_o,
   output logic [ASN_W-1:0] rsp_asn_o,
   output logic             rsp_global_o,
   output logic [MODES-1:0] rsp_rd_en_o,
   output logic [MODES-1:0] rsp_wr_en_o,
   output logic             rsp_for_o,
   output logic             rsp_fow_o
);

   generate
      if (DEPTH < 2)               begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (VA_W <= PAGE_BITS)       begin : g_bad_va    $error("VA_W must exceed PAGE_BITS"); end
      if (ASN_W < 1 || PPN_W < 1)  begin : g_bad_w     $error("field widths must be positive"); end
      if (MODES < 1)               begin : g_bad_modes $error("MODES must be positive"); end
   endgenerate

   tlb_cmd_e cmd;
   logic is_lookup, is_ins, is_all, is_proc, is_faddr;
   assign cmd       = tlb_cmd_e'(cmd_i);
   assign is_lookup = (cmd == CMD_LOOKUP);
   assign is_ins    = (cmd == CMD_INSERT);
   assign is_all    = (cmd == CMD_FLUSH_ALL);
   assign is_proc   = (cmd == CMD_FLUSH_PROC);
   assign is_faddr  = (cmd == CMD_FLUSH_ADDR);

   logic [VPN_W-1:0]     vpn;
   logic [PAGE_BITS-1:0] unused_offset;
   assign vpn           = va_i[VA_W-1:PAGE_BITS];
   assign unused_offset = va_i[PAGE_BITS-1:0];

   logic [IDX_W-1:0] victim;
   tlb_victim #(.DEPTH(DEPTH)) victim_i (
      .clk(clk), .rst_n(rst_n), .adv_i(is_ins), .clr_i(is_all), .ptr_o(victim)
   );

   logic [DEPTH-1:0] match_vec, valid_vec, glob_vec;
   logic [PPN_W-1:0] s_ppn [DEPTH];
   logic [ASN_W-1:0] s_asn [DEPTH];
   logic [MODES-1:0] s_rd  [DEPTH];
   logic [MODES-1:0] s_wm  [DEPTH];
   logic [DEPTH-1:0] s_for, s_fow;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic wr, kill;
      assign wr   = is_ins && (victim == IDX_W'(i));
      assign kill = (is_proc && !glob_vec[i]) || (is_faddr && match_vec[i]);
      tlb_slot #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) slot_i (
         .clk(clk), .rst_n(rst_n), .clr_i(is_all), .wr_i(wr), .kill_i(kill),
         .wr_tag_i(vpn), .wr_ppn_i(ins_ppn_i), .wr_asn_i(asn_i), .wr_glob_i(ins_global_i),
         .wr_rd_i(ins_rd_en_i), .wr_wm_i(ins_wr_en_i), .wr_for_i(ins_for_i), .wr_fow_i(ins_fow_i),
         .lk_vpn_i(vpn), .lk_asn_i(asn_i),
         .match_o(match_vec[i]), .valid_o(valid_vec[i]), .glob_o(glob_vec[i]),
         .ppn_o(s_ppn[i]), .asn_o(s_asn[i]), .rd_o(s_rd[i]), .wm_o(s_wm[i]),
         .for_o(s_for[i]), .fow_o(s_fow[i])
      );
   end

   logic             any_hit;
   logic [IDX_W-1:0] hit_idx;
   tlb_first_hit #(.N(DEPTH)) first_i (.vec_i(match_vec), .any_o(any_hit), .idx_o(hit_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o  <= 1'b0;
         rsp_hit_o    <= 1'b0;
         rsp_idx_o    <= '0;
         rsp_ppn_o    <= '0;
         rsp_asn_o    <= '0;
         rsp_global_o <= 1'b0;
         rsp_rd_en_o  <= '0;
         rsp_wr_en_o  <= '0;
         rsp_for_o    <= 1'b0;
         rsp_fow_o    <= 1'b0;
      end else begin
         rsp_valid_o  <= is_lookup;
         rsp_hit_o    <= is_lookup && any_hit;
         rsp_idx_o    <= (is_lookup && any_hit) ? hit_idx : '0;
         rsp_ppn_o    <= (is_lookup && any_hit) ? s_ppn[hit_idx] : '0;
         rsp_asn_o    <= (is_lookup && any_hit) ? s_asn[hit_idx] : '0;
         rsp_global_o <= is_lookup && any_hit && glob_vec[hit_idx];
         rsp_rd_en_o  <= (is_lookup && any_hit) ? s_rd[hit_idx] : '0;
         rsp_wr_en_o  <= (is_lookup && any_hit) ? s_wm[hit_idx] : '0;
         rsp_for_o    <= is_lookup && any_hit && s_for[hit_idx];
         rsp_fow_o    <= is_lookup && any_hit && s_fow[hit_idx];
      end
   end

   AST_RSP_AFTER_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      is_lookup |=> rsp_valid_o); // R8
   AST_RSP_ONLY_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
      !is_lookup |=> !rsp_valid_o && !rsp_hit_o); // R8
   AST_MISS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o && !rsp_hit_o |-> rsp_ppn_o == '0 && rsp_rd_en_o == '0 && !rsp_global_o); // R8
   AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      is_all |=> valid_vec == '0); // R5
   AST_PROC_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
      is_proc |=> valid_vec == $past(valid_vec & glob_vec)); // R6
   AST_IDLE_KEEPS_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
      !is_ins && !is_all && !is_proc && !is_faddr |=> $stable(valid_vec)); // R10

endmodule

// File: tb/asn_tlb_tb_top.sv
`timescale 1ns/1ps
module asn_tlb_tb_top;

   localparam int DEPTH = 4;
   localparam int VA_W  = 43;
   localparam int PB    = 13;
   localparam int PPN_W = 28;
   localparam int ASN_W = 8;
   localparam int MODES = 4;
   localparam int VPN_W = VA_W - PB;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int NV    = 8;

   localparam logic [VPN_W-1:0] T_VPN [NV] = '{30'h10, 30'h10, 30'h10, 30'h20, 30'h20, 30'h30, 30'h31, 30'h40};
   localparam logic [ASN_W-1:0] T_ASN [NV] = '{8'd3, 8'd7, 8'd9, 8'd9, 8'd5, 8'd3, 8'd3, 8'd3};
   localparam logic [PB-1:0]    T_OFF [NV] = '{13'h0, 13'h4, 13'h0, 13'h123, 13'h0, 13'h1FFF, 13'h0, 13'h0};
   localparam logic             T_HIT [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic [IDX_W-1:0] T_IDX [NV] = '{2'd0, 2'd2, 2'd0, 2'd1, 2'd1, 2'd3, 2'd0, 2'd0};
   localparam logic [PPN_W-1:0] T_PPN [NV] = '{28'h100, 28'h300, 28'h0, 28'h200, 28'h200, 28'h400, 28'h0, 28'h0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0]       cmd_i = 3'd0;
   logic [VA_W-1:0]  va_i = '0;
   logic [ASN_W-1:0] asn_i = '0;
   logic [PPN_W-1:0] ins_ppn_i = '0;
   logic             ins_global_i = 1'b0;
   logic [MODES-1:0] ins_rd_en_i = '0;
   logic [MODES-1:0] ins_wr_en_i = '0;
   logic             ins_for_i = 1'b0;
   logic             ins_fow_i = 1'b0;
   logic             rsp_valid_o, rsp_hit_o, rsp_global_o, rsp_for_o, rsp_fow_o;
   logic [IDX_W-1:0] rsp_idx_o;
   logic [PPN_W-1:0] rsp_ppn_o;
   logic [ASN_W-1:0] rsp_asn_o;
   logic [MODES-1:0] rsp_rd_en_o, rsp_wr_en_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   asn_tlb #(.DEPTH(DEPTH), .VA_W(VA_W), .PAGE_BITS(PB), .PPN_W(PPN_W),
             .ASN_W(ASN_W), .MODES(MODES)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .va_i(va_i), .asn_i(asn_i),
      .ins_ppn_i(ins_ppn_i), .ins_global_i(ins_global_i), .ins_rd_en_i(ins_rd_en_i),
      .ins_wr_en_i(ins_wr_en_i), .ins_for_i(ins_for_i), .ins_fow_i(ins_fow_i),
      .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_idx_o(rsp_idx_o),
      .rsp_ppn_o(rsp_ppn_o), .rsp_asn_o(rsp_asn_o), .rsp_global_o(rsp_global_o),
      .rsp_rd_en_o(rsp_rd_en_o), .rsp_wr_en_o(rsp_wr_en_o),
      .rsp_for_o(rsp_for_o), .rsp_fow_o(rsp_fow_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one command for one cycle; outputs of that edge are visible on return
   task automatic issue(input logic [2:0] c, input logic [VPN_W-1:0] vpn,
                        input logic [ASN_W-1:0] asn, input logic [PB-1:0] off);
      @(negedge clk);
      cmd_i = c;
      va_i  = {vpn, off};
      asn_i = asn;
      @(negedge clk);
      cmd_i = 3'd0;
   endtask

   task automatic ins(input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                      input logic g, input logic [PPN_W-1:0] ppn,
                      input logic [MODES-1:0] rd, input logic [MODES-1:0] wm,
                      input logic fr, input logic fw);
      ins_ppn_i = ppn; ins_global_i = g; ins_rd_en_i = rd; ins_wr_en_i = wm;
      ins_for_i = fr; ins_fow_i = fw;
      issue(3'd2, vpn, asn, 13'h0);
   endtask

   task automatic look(input string req, input logic [VPN_W-1:0] vpn, input logic [ASN_W-1:0] asn,
                       input logic hit, input logic [IDX_W-1:0] idx, input logic [PPN_W-1:0] ppn);
      issue(3'd1, vpn, asn, 13'h0);
      chk({req, " valid"}, 64'(rsp_valid_o), 64'(1'b1));
      chk({req, " hit"}, 64'(rsp_hit_o), 64'(hit));
      if (hit) chk({req, " idx"}, 64'(rsp_idx_o), 64'(idx));
      chk({req, " ppn"}, 64'(rsp_ppn_o), 64'(ppn));
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid in reset", 64'(rsp_valid_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_valid after reset", 64'(rsp_valid_o), 64'd0);
      look("R1 empty lookup", 30'h10, 8'd3, 1'b0, 2'd0, 28'h0);
      @(negedge clk);
      chk("R8 valid drops after idle", 64'(rsp_valid_o), 64'd0);

      // fill slots 0..3 in pointer order
      ins(30'h10, 8'd3, 1'b0, 28'h100, 4'b0011, 4'b0001, 1'b0, 1'b1);
      ins(30'h20, 8'd5, 1'b1, 28'h200, 4'b1111, 4'b0000, 1'b1, 1'b0);
      ins(30'h10, 8'd7, 1'b0, 28'h300, 4'b0100, 4'b0100, 1'b0, 1'b0);
      ins(30'h30, 8'd3, 1'b0, 28'h400, 4'b0001, 4'b0010, 1'b0, 1'b0);

      // table walk: R2 match rule, offset ignored, R8 miss fields
      for (int k = 0; k < NV; k++) begin
         issue(3'd1, T_VPN[k], T_ASN[k], T_OFF[k]);
         chk($sformatf("R2 vec%0d hit", k), 64'(rsp_hit_o), 64'(T_HIT[k]));
         chk($sformatf("R8 vec%0d ppn", k), 64'(rsp_ppn_o), 64'(T_PPN[k]));
         if (T_HIT[k]) chk($sformatf("R2 vec%0d idx", k), 64'(rsp_idx_o), 64'(T_IDX[k]));
      end

      // R4 stored fields
      issue(3'd1, 30'h20, 8'd1, 13'h0);
      chk("R4 global", 64'(rsp_global_o), 64'd1);
      chk("R4 rd_en", 64'(rsp_rd_en_o), 64'hF);
      chk("R4 for", 64'(rsp_for_o), 64'd1);
      chk("R4 asn", 64'(rsp_asn_o), 64'd5);
      issue(3'd1, 30'h10, 8'd3, 13'h0);
      chk("R4 wr_en", 64'(rsp_wr_en_o), 64'h1);
      chk("R4 fow", 64'(rsp_fow_o), 64'd1);
      chk("R4 rd_en slot0", 64'(rsp_rd_en_o), 64'h3);

      // R10 unused code acts as idle
      issue(3'd6, 30'h10, 8'd3, 13'h0);
      chk("R10 code6 no response", 64'(rsp_valid_o), 64'd0);
      issue(3'd7, 30'h20, 8'd5, 13'h0);
      look("R10 slot kept", 30'h10, 8'd3, 1'b1, 2'd0, 28'h100);

      // R3 wrap: fifth insert lands in slot 0, duplicates slot 3 page/asn
      ins(30'h30, 8'd3, 1'b0, 28'h500, 4'b0001, 4'b0001, 1'b0, 1'b0);
      look("R9 lowest index", 30'h30, 8'd3, 1'b1, 2'd0, 28'h500);
      look("R3 evicted slot0", 30'h10, 8'd3, 1'b0, 2'd0, 28'h0);
      ins(30'h50, 8'd1, 1'b0, 28'h600, 4'b0001, 4'b0001, 1'b0, 1'b0);
      look("R3 global evicted", 30'h20, 8'd9, 1'b0, 2'd0, 28'h0);
      look("R3 slot1 new", 30'h50, 8'd1, 1'b1, 2'd1, 28'h600);

      // R7 flush by address
      issue(3'd5, 30'h10, 8'd8, 13'h0);
      look("R7 other asn kept", 30'h10, 8'd7, 1'b1, 2'd2, 28'h300);
      issue(3'd5, 30'h30, 8'd3, 13'h0);
      look("R7 both duplicates gone", 30'h30, 8'd3, 1'b0, 2'd0, 28'h0);

      // R6 flush process keeps global
      ins(30'h60, 8'd2, 1'b1, 28'h700, 4'b0001, 4'b0001, 1'b0, 1'b0);
      issue(3'd4, 30'h0, 8'd0, 13'h0);
      look("R6 global survives", 30'h60, 8'd4, 1'b1, 2'd2, 28'h700);
      look("R6 non-global gone", 30'h50, 8'd1, 1'b0, 2'd0, 28'h0);

      // R7 global removed whatever asn
      issue(3'd5, 30'h60, 8'd9, 13'h0);
      look("R7 global flushed", 30'h60, 8'd2, 1'b0, 2'd0, 28'h0);

      // R5 flush all resets pointer
      ins(30'h70, 8'd0, 1'b1, 28'h800, 4'b0001, 4'b0001, 1'b0, 1'b0);
      ins(30'h71, 8'd0, 1'b1, 28'h900, 4'b0001, 4'b0001, 1'b0, 1'b0);
      issue(3'd3, 30'h0, 8'd0, 13'h0);
      look("R5 flushed", 30'h70, 8'd0, 1'b0, 2'd0, 28'h0);
      ins(30'h80, 8'd0, 1'b0, 28'hA00, 4'b0001, 4'b0001, 1'b0, 1'b0);
      look("R5 pointer back to 0", 30'h80, 8'd0, 1'b1, 2'd0, 28'hA00);

      @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule